// File: doc/BRIEF.md
# Banked Group 1 Binary Point Register

This block holds the 3-bit binary point that splits an 8-bit Group 1 interrupt priority into a preemption part and a subpriority part. It keeps three stored copies: one for the Secure state, one for the Non-secure state and one used when interrupts are routed to a virtual interface. The three copies leave the block as plain outputs for the priority logic that consumes them.

A 32-bit access port receives decoded coprocessor-style reads and writes, together with the exception level, the security state and the control bits that govern routing. For every access that matches the register's encoding, a prioritized chain of checks picks one of four outcomes. The access may complete against one of the copies, or it may be refused as undefined, trapped to EL2 or trapped to EL3. Writes are normalized before they are stored. When the common binary point control is set, a Non-secure access sees the Group 0 binary point plus one instead of its own copy. The response is registered and appears one cycle after the access strobe.

Top module: `irq_bp_reg`

## Requirements
- R1: After reset each of the three copies holds the nonzero parameter `RST_BP` (default 2), and `rsp_valid_o` is low.
- R2: An access is answered only when coprocessor 15, opc1 0, CRn 12, CRm 12 and opc2 3 are all presented. `rsp_valid_o` then rises exactly one cycle after the strobe. Any other encoding produces no response.
- R3: Only bits [2:0] are stored. Response data bits [31:3] are always zero, and write data bits [31:3] are dropped.
- R4: Writing 0 to any copy stores `RST_BP`.
- R5: With `HAS_EL3` = 0 there is a single copy, held in the Non-secure slot. A write below `RST_BP` stores `RST_BP`, an EL3 access is undefined, and the IRQ routing bit never traps.
- R6: Outcome codes are 0 completed, 1 undefined, 2 trap to EL2 and 3 trap to EL3. `rsp_syn_o` is 0x03 on either trap and 0 otherwise. Any access from EL0 (`el_i` = 0) is undefined.
- R7: At EL3 the copy is chosen by `ns_i`: 0 selects the Secure copy and 1 the Non-secure copy. A completed access at EL1 or EL2 that is not virtualized uses the Non-secure copy.
- R8: At EL1 the checks are made in this order:
  1. with EL2 enabled, `hyp_trap_grp_i` traps to EL2;
  2. `sre_el1_i` = 0 is undefined;
  3. with EL2 enabled, `hyp_trap_all_i` traps to EL2;
  4. with EL2 enabled, `virt_route_i` completes on the virtual copy;
  5. `irq_route_i` traps to EL3 unless `monitor_i` is set;
  6. otherwise the access completes on the Non-secure copy.
- R9: At EL2, `sre_el2_i` = 0 is undefined. Otherwise `irq_route_i` traps to EL3, and otherwise the access completes on the Non-secure copy.
- R10: When `common_bp_i` is set, a completed Non-secure access at EL1 or EL2 reads `grp0_bp_i`+1, saturated at 7, and its write is ignored.
- R11: When `sdd_prio_i` and `irq_route_i` are both set, the access is undefined ahead of every other check. This applies at EL2, and at EL1 when `monitor_i` is clear.
- R12: An access that does not complete leaves all copies unchanged. Response data is zero for writes and for accesses that do not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access strobe, one cycle per access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_coproc_i | input | 4 | Coprocessor number |
| acc_opc1_i | input | 3 | First opcode field |
| acc_crn_i | input | 4 | Primary register field |
| acc_crm_i | input | 4 | Secondary register field |
| acc_opc2_i | input | 3 | Second opcode field |
| acc_wdata_i | input | 32 | Write data |
| el_i | input | 2 | Exception level of the access |
| ns_i | input | 1 | Non-secure state bit |
| monitor_i | input | 1 | Core is in monitor mode |
| el2_en_i | input | 1 | EL2 is enabled in the current state |
| sdd_prio_i | input | 1 | Secure debug disable takes priority as undefined |
| irq_route_i | input | 1 | IRQs are routed to EL3 |
| hyp_trap_grp_i | input | 1 | Hypervisor trap of this register group |
| sre_el1_i | input | 1 | System register interface enabled at EL1 |
| hyp_trap_all_i | input | 1 | Hypervisor trap of all Group 1 accesses |
| virt_route_i | input | 1 | IRQs are virtualized by EL2 |
| sre_el2_i | input | 1 | System register interface enabled at EL2 |
| common_bp_i | input | 1 | Non-secure Group 1 uses the Group 0 binary point |
| grp0_bp_i | input | 3 | Current Group 0 binary point |
| rsp_valid_o | output | 1 | Response valid |
| rsp_code_o | output | 2 | Outcome code |
| rsp_syn_o | output | 6 | Trap syndrome code |
| rsp_rdata_o | output | 32 | Read data |
| bp_sec_o | output | 3 | Secure copy |
| bp_nsec_o | output | 3 | Non-secure copy |
| bp_virt_o | output | 3 | Virtual copy |

## Verification
Several checks can be true for the same access: the secure-debug undefined check, the hypervisor traps, the enable bits, virtual routing, the EL3 trap and common-binary-point aliasing. The priority chain has to choose exactly one of them. The bench drives every combination of exception level and control bits as a write followed by a read. A reference model built from the requirements decides which check wins, and the bench compares the outcome, the syndrome, the read data and all three copies. Directed cases set pairs of checks together, such as a group trap with the enable bit clear, or the secure-debug bit with a group trap, and test which outcome appears.

// File: rtl/irq_bp_pkg.sv
package irq_bp_pkg;
  localparam int BP_W     = 3;
  localparam int NUM_BANK = 3;
  localparam int SYN_W    = 6;
  localparam logic [SYN_W-1:0] TRAP_SYN = 6'h03;

  typedef enum logic [1:0] {
    RSP_DONE     = 2'd0,
    RSP_UNDEF    = 2'd1,
    RSP_TRAP_EL2 = 2'd2,
    RSP_TRAP_EL3 = 2'd3
  } rsp_code_e;

  // index into the bank array
  typedef enum logic [1:0] {
    SEL_SEC  = 2'd0,
    SEL_NSEC = 2'd1,
    SEL_VIRT = 2'd2,
    SEL_NONE = 2'd3
  } bank_sel_e;

  typedef struct packed {
    rsp_code_e code;
    bank_sel_e sel;
    logic      alias_g0;
  } route_t;
endpackage

// File: rtl/irq_bp_decode.sv
module irq_bp_decode #(
  parameter logic [3:0] ENC_COPROC = 4'd15,
  parameter logic [2:0] ENC_OPC1   = 3'd0,
  parameter logic [3:0] ENC_CRN    = 4'd12,
  parameter logic [3:0] ENC_CRM    = 4'd12,
  parameter logic [2:0] ENC_OPC2   = 3'd3
) (
  input  logic [3:0] coproc_i,
  input  logic [2:0] opc1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] opc2_i,
  output logic       hit_o
);
  assign hit_o = (coproc_i == ENC_COPROC) && (opc1_i == ENC_OPC1) &&
                 (crn_i == ENC_CRN) && (crm_i == ENC_CRM) && (opc2_i == ENC_OPC2);
endmodule

// File: rtl/irq_bp_route.sv
module irq_bp_route
  import irq_bp_pkg::*;
#(
  parameter bit HAS_EL3 = 1'b1
) (
  input  logic [1:0] el_i,
  input  logic       ns_i,
  input  logic       monitor_i,
  input  logic       el2_en_i,
  input  logic       sdd_prio_i,
  input  logic       irq_route_i,
  input  logic       hyp_trap_grp_i,
  input  logic       sre_el1_i,
  input  logic       hyp_trap_all_i,
  input  logic       virt_route_i,
  input  logic       sre_el2_i,
  input  logic       common_bp_i,
  output route_t     route_o
);
  logic irq_el1, irq_el2;
  assign irq_el1 = HAS_EL3 && irq_route_i && !monitor_i;
  assign irq_el2 = HAS_EL3 && irq_route_i;

  always_comb begin
    route_o = '{code: RSP_UNDEF, sel: SEL_NONE, alias_g0: 1'b0};
    unique case (el_i)
      2'd1: begin
        if (irq_el1 && sdd_prio_i)            route_o.code = RSP_UNDEF;
        else if (el2_en_i && hyp_trap_grp_i)  route_o.code = RSP_TRAP_EL2;
        else if (!sre_el1_i)                  route_o.code = RSP_UNDEF;
        else if (el2_en_i && hyp_trap_all_i)  route_o.code = RSP_TRAP_EL2;
        else if (el2_en_i && virt_route_i)    route_o = '{RSP_DONE, SEL_VIRT, 1'b0};
        else if (irq_el1)                     route_o.code = RSP_TRAP_EL3;
        else                                  route_o = '{RSP_DONE, SEL_NSEC, common_bp_i};
      end
      2'd2: begin
        if (irq_el2 && sdd_prio_i)            route_o.code = RSP_UNDEF;
        else if (!sre_el2_i)                  route_o.code = RSP_UNDEF;
        else if (irq_el2)                     route_o.code = RSP_TRAP_EL3;
        else                                  route_o = '{RSP_DONE, SEL_NSEC, common_bp_i};
      end
      2'd3: begin
        if (HAS_EL3) route_o = '{RSP_DONE, ns_i ? SEL_NSEC : SEL_SEC, 1'b0};
      end
      default: route_o.code = RSP_UNDEF;
    endcase
  end
endmodule

// File: rtl/irq_bp_store.sv
module irq_bp_store
  import irq_bp_pkg::*;
#(
  parameter int              N_BANK   = NUM_BANK,
  parameter logic [BP_W-1:0] RST_BP   = 3'd2,
  parameter bit              FLOOR_EN = 1'b0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_BANK-1:0]           wr_en_i,
  input  logic [BP_W-1:0]             wr_val_i,
  output logic [N_BANK-1:0][BP_W-1:0] bank_o
);
  logic [BP_W-1:0] wr_norm;
  assign wr_norm = ((wr_val_i == '0) || (FLOOR_EN && (wr_val_i < RST_BP))) ? RST_BP : wr_val_i;

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          bank_o[g] <= RST_BP;
      else if (wr_en_i[g])  bank_o[g] <= wr_norm;
    end

    a_r1_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_o[g] != '0);

    a_r4_zero_loads_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[g] && (wr_val_i == '0) |=> bank_o[g] == RST_BP);

    if (FLOOR_EN) begin : g_floor
      a_r5_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bank_o[g] >= RST_BP);
    end
  end
endmodule

// File: rtl/irq_bp_reg.sv
module irq_bp_reg
  import irq_bp_pkg::*;
#(
  parameter int              DATA_W  = 32,
  parameter logic [BP_W-1:0] RST_BP  = 3'd2,
  parameter bit              HAS_EL3 = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [3:0]        acc_coproc_i,
  input  logic [2:0]        acc_opc1_i,
  input  logic [3:0]        acc_crn_i,
  input  logic [3:0]        acc_crm_i,
  input  logic [2:0]        acc_opc2_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic [1:0]        el_i,
  input  logic              ns_i,
  input  logic              monitor_i,
  input  logic              el2_en_i,
  input  logic              sdd_prio_i,
  input  logic              irq_route_i,
  input  logic              hyp_trap_grp_i,
  input  logic              sre_el1_i,
  input  logic              hyp_trap_all_i,
  input  logic              virt_route_i,
  input  logic              sre_el2_i,
  input  logic              common_bp_i,
  input  logic [BP_W-1:0]   grp0_bp_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_code_o,
  output logic [SYN_W-1:0]  rsp_syn_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [BP_W-1:0]   bp_sec_o,
  output logic [BP_W-1:0]   bp_nsec_o,
  output logic [BP_W-1:0]   bp_virt_o
);
  localparam logic [BP_W-1:0] BP_MAX = '1;

  logic                          enc_hit, acc_go;
  route_t                        route;
  logic [NUM_BANK-1:0]           wr_en;
  logic [NUM_BANK-1:0][BP_W-1:0] bank;
  logic [BP_W-1:0]               g0_plus, rd_bp;

  irq_bp_decode u_decode (
    .coproc_i (acc_coproc_i),
    .opc1_i   (acc_opc1_i),
    .crn_i    (acc_crn_i),
    .crm_i    (acc_crm_i),
    .opc2_i   (acc_opc2_i),
    .hit_o    (enc_hit)
  );

  irq_bp_route #(.HAS_EL3(HAS_EL3)) u_route (
    .el_i           (el_i),
    .ns_i           (ns_i),
    .monitor_i      (monitor_i),
    .el2_en_i       (el2_en_i),
    .sdd_prio_i     (sdd_prio_i),
    .irq_route_i    (irq_route_i),
    .hyp_trap_grp_i (hyp_trap_grp_i),
    .sre_el1_i      (sre_el1_i),
    .hyp_trap_all_i (hyp_trap_all_i),
    .virt_route_i   (virt_route_i),
    .sre_el2_i      (sre_el2_i),
    .common_bp_i    (common_bp_i),
    .route_o        (route)
  );

  assign acc_go  = acc_valid_i && enc_hit;
  assign g0_plus = (grp0_bp_i == BP_MAX) ? BP_MAX : grp0_bp_i + 1'b1;

  always_comb begin
    wr_en = '0;
    if (acc_go && acc_write_i && route.code == RSP_DONE && route.sel != SEL_NONE && !route.alias_g0)
      wr_en[route.sel] = 1'b1;
  end

  always_comb begin
    if (route.alias_g0)            rd_bp = g0_plus;
    else if (route.sel != SEL_NONE) rd_bp = bank[route.sel];
    else                           rd_bp = '0;
  end

  irq_bp_store #(.N_BANK(NUM_BANK), .RST_BP(RST_BP), .FLOOR_EN(!HAS_EL3)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_val_i (acc_wdata_i[BP_W-1:0]),
    .bank_o   (bank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= RSP_DONE;
      rsp_syn_o   <= '0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= acc_go;
      if (acc_go) begin
        rsp_code_o  <= route.code;
        rsp_syn_o   <= (route.code == RSP_TRAP_EL2 || route.code == RSP_TRAP_EL3) ? TRAP_SYN : '0;
        rsp_rdata_o <= (route.code == RSP_DONE && !acc_write_i) ?
                       DATA_W'(rd_bp) : '0;
      end
    end
  end

  assign bp_sec_o  = bank[SEL_SEC];
  assign bp_nsec_o = bank[SEL_NSEC];
  assign bp_virt_o = bank[SEL_VIRT];

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && enc_hit |=> rsp_valid_o);
  a_r2_miss_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_valid_i && enc_hit) |=> !rsp_valid_o);
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_rdata_o[DATA_W-1:BP_W] == '0);
  a_r6_el0_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && enc_hit && el_i == 2'd0 |=> rsp_code_o == RSP_UNDEF);
  a_r11_sdd_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && enc_hit && HAS_EL3 && sdd_prio_i && irq_route_i &&
    (el_i == 2'd2 || (el_i == 2'd1 && !monitor_i)) |=> rsp_code_o == RSP_UNDEF);
  a_r12_hold_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_code_o != RSP_DONE |->
      bp_sec_o == $past(bp_sec_o) && bp_nsec_o == $past(bp_nsec_o) &&
      bp_virt_o == $past(bp_virt_o));
  a_r10_alias_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_go && acc_write_i && route.alias_g0 |=> $stable(bp_nsec_o));
endmodule

// File: tb/irq_bp_reg_test.sv
module irq_bp_reg_test;
  localparam int CLK_P = 10;
  localparam logic [2:0] RST = 3'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 0, wr = 0;
  logic [3:0] cp = 4'd15, crn = 4'd12, crm = 4'd12;
  logic [2:0] o1 = 3'd0, o2 = 3'd3;
  logic [31:0] wd = '0;
  logic [1:0] el = 0;
  logic ns = 0, mon = 0, e2 = 0, sdd = 0, irq = 0, tg = 0, s1 = 1, ta = 0, vr = 0, s2 = 1, cb = 0;
  logic [2:0] g0 = 0;

  logic v_o, n_v;
  logic [1:0] c_o, n_c;
  logic [5:0] y_o, n_y;
  logic [31:0] d_o, n_d;
  logic [2:0] bs, bn, bv, n_bs, n_bn, n_bv;

  int n_run = 0, n_fail = 0;
  logic [2:0] m_bank [3];

  always #(CLK_P/2) clk = ~clk;

  irq_bp_reg #(.RST_BP(RST), .HAS_EL3(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(vld), .acc_write_i(wr),
    .acc_coproc_i(cp), .acc_opc1_i(o1), .acc_crn_i(crn), .acc_crm_i(crm), .acc_opc2_i(o2),
    .acc_wdata_i(wd), .el_i(el), .ns_i(ns), .monitor_i(mon), .el2_en_i(e2), .sdd_prio_i(sdd),
    .irq_route_i(irq), .hyp_trap_grp_i(tg), .sre_el1_i(s1), .hyp_trap_all_i(ta),
    .virt_route_i(vr), .sre_el2_i(s2), .common_bp_i(cb), .grp0_bp_i(g0),
    .rsp_valid_o(v_o), .rsp_code_o(c_o), .rsp_syn_o(y_o), .rsp_rdata_o(d_o),
    .bp_sec_o(bs), .bp_nsec_o(bn), .bp_virt_o(bv));

  irq_bp_reg #(.RST_BP(RST), .HAS_EL3(1'b0)) uut_n3 (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(vld), .acc_write_i(wr),
    .acc_coproc_i(cp), .acc_opc1_i(o1), .acc_crn_i(crn), .acc_crm_i(crm), .acc_opc2_i(o2),
    .acc_wdata_i(wd), .el_i(el), .ns_i(ns), .monitor_i(mon), .el2_en_i(e2), .sdd_prio_i(sdd),
    .irq_route_i(irq), .hyp_trap_grp_i(tg), .sre_el1_i(s1), .hyp_trap_all_i(ta),
    .virt_route_i(vr), .sre_el2_i(s2), .common_bp_i(cb), .grp0_bp_i(g0),
    .rsp_valid_o(n_v), .rsp_code_o(n_c), .rsp_syn_o(n_y), .rsp_rdata_o(n_d),
    .bp_sec_o(n_bs), .bp_nsec_o(n_bn), .bp_virt_o(n_bv));

  // el, wr, ns, wdata, code, rdata -- controls at defaults (enables on, rest off)
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {2'd3, 1'b1, 1'b0, 3'd5, 2'd0, 3'd0},
    {2'd3, 1'b0, 1'b0, 3'd0, 2'd0, 3'd5},
    {2'd3, 1'b0, 1'b1, 3'd0, 2'd0, 3'd2},
    {2'd1, 1'b0, 1'b0, 3'd0, 2'd0, 3'd2},
    {2'd1, 1'b1, 1'b0, 3'd0, 2'd0, 3'd0},
    {2'd3, 1'b1, 1'b0, 3'd0, 2'd0, 3'd0},
    {2'd3, 1'b0, 1'b0, 3'd0, 2'd0, 3'd2},
    {2'd2, 1'b1, 1'b0, 3'd6, 2'd0, 3'd0},
    {2'd3, 1'b0, 1'b1, 3'd0, 2'd0, 3'd6},
    {2'd0, 1'b0, 1'b0, 3'd0, 2'd1, 3'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [31:0] d);
    @(negedge clk);
    vld = 1'b1; wr = w; wd = d;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) m_bank[i] = RST;
  endtask

  task automatic set_ctl(input logic [1:0] e, input logic n);
    el = e; ns = n; mon = 0; e2 = 0; sdd = 0; irq = 0; tg = 0; s1 = 1; ta = 0; vr = 0; s2 = 1; cb = 0; g0 = 0;
  endtask

  // reference model for the EL3-present instance
  task automatic model(input logic w, input logic [31:0] d,
                       output logic [1:0] code, output logic [5:0] syn, output logic [31:0] rd);
    int sel; logic al; logic [2:0] val;
    sel = -1; al = 0; code = 2'd1;
    case (el)
      2'd1: begin
        if (sdd && irq && !mon)  code = 2'd1;
        else if (e2 && tg)       code = 2'd2;
        else if (!s1)            code = 2'd1;
        else if (e2 && ta)       code = 2'd2;
        else if (e2 && vr)       begin code = 2'd0; sel = 2; end
        else if (irq && !mon)    code = 2'd3;
        else                     begin code = 2'd0; sel = 1; al = cb; end
      end
      2'd2: begin
        if (sdd && irq)          code = 2'd1;
        else if (!s2)            code = 2'd1;
        else if (irq)            code = 2'd3;
        else                     begin code = 2'd0; sel = 1; al = cb; end
      end
      2'd3: begin code = 2'd0; sel = ns ? 1 : 0; end
      default: code = 2'd1;
    endcase
    syn = (code >= 2'd2) ? 6'h03 : 6'h00;
    rd = '0;
    if (code == 2'd0) begin
      if (w) begin
        val = (d[2:0] == 3'd0) ? RST : d[2:0];
        if (!al) m_bank[sel] = val;
      end else begin
        rd = al ? {29'd0, (g0 == 3'd7) ? 3'd7 : g0 + 3'd1} : {29'd0, m_bank[sel]};
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", {v_o, bs, bn, bv}, {1'b0, RST, RST, RST});
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) m_bank[i] = RST;

    // table: banking and write normalisation (R7, R4, R6)
    for (int i = 0; i < NV; i++) begin
      set_ctl(VEC[i][11:10], VEC[i][8]);
      acc(VEC[i][9], {29'h1FFF_FFF0, VEC[i][7:5]});
      chk($sformatf("R7 R4 R6 table %0d", i), {v_o, c_o, d_o},
          {1'b1, VEC[i][4:3], 29'd0, VEC[i][2:0]});
    end

    // R2 encoding miss gives no response and no write
    set_ctl(2'd3, 1'b0); crm = 4'd13;
    acc(1'b1, 32'd6);
    chk("R2 miss", {v_o, bs}, {1'b0, 3'd2});
    crm = 4'd12;

    // R3 upper write bits dropped, upper read bits zero
    acc(1'b1, 32'hFFFF_FFFD);
    acc(1'b0, 32'd0);
    chk("R3 upper", d_o, 32'd5);

    // R10 alias saturates and write ignored
    set_ctl(2'd1, 1'b0); cb = 1; g0 = 3'd7;
    acc(1'b0, 0);
    chk("R10 sat", d_o, 32'd7);
    g0 = 3'd3;
    acc(1'b0, 0);
    chk("R10 plus1", d_o, 32'd4);
    acc(1'b1, 32'd6);
    chk("R10 write ignored", {c_o, bn}, {2'd0, 3'd6});

    // R8 group trap ranks above disabled enable
    set_ctl(2'd1, 1'b0); e2 = 1; tg = 1; s1 = 0;
    acc(1'b1, 32'd3);
    chk("R8 order", {c_o, y_o, bn}, {2'd2, 6'h03, 3'd6});
    // R11 secure-debug ranks above group trap
    sdd = 1; irq = 1;
    acc(1'b1, 32'd3);
    chk("R11 first", {c_o, y_o, d_o}, {2'd1, 6'h00, 32'd0});
    // R9 EL2 irq trap
    set_ctl(2'd2, 1'b0); irq = 1;
    acc(1'b0, 0);
    chk("R9 trap", {c_o, y_o, d_o}, {2'd3, 6'h03, 32'd0});

    // exhaustive sweep against the model (R6 R7 R8 R9 R10 R11 R12)
    do_reset();
    for (int k = 0; k < 8192; k++) begin
      logic [1:0] ec; logic [5:0] es; logic [31:0] er; logic [31:0] dd;
      el = k[1:0]; irq = k[2]; vr = k[3]; ns = k[4]; s1 = k[5]; s2 = k[6];
      tg = k[7]; ta = k[8]; cb = k[9]; sdd = k[10]; e2 = k[11]; mon = k[12];
      g0 = k[2:0] ^ k[12:10];
      for (int p = 0; p < 2; p++) begin
        dd = 32'hA5A5_A5A0 | 32'((k * 3 + p) % 8);
        model(p == 0, dd, ec, es, er);
        acc(p == 0, dd);
        chk("R8 R9 R11 R12 sweep", {v_o, c_o, y_o, d_o, bs, bn, bv},
            {1'b1, ec, es, er, m_bank[0], m_bank[1], m_bank[2]});
      end
    end

    // R5 instance without EL3
    do_reset();
    set_ctl(2'd1, 1'b0);
    acc(1'b1, 32'd1);
    chk("R5 floor", {n_c, n_bn}, {2'd0, RST});
    acc(1'b1, 32'd5);
    chk("R5 above floor", n_bn, 3'd5);
    set_ctl(2'd3, 1'b0);
    acc(1'b0, 0);
    chk("R5 el3 undef", {n_v, n_c, n_d}, {1'b1, 2'd1, 32'd0});
    set_ctl(2'd1, 1'b0); irq = 1;
    acc(1'b0, 0);
    chk("R5 no irq trap", {n_c, n_d}, {2'd0, 32'd5});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule